// File: doc/BRIEF.md
# Serial Configuration Register Bank for an Imaging Front End

This block is a three-wire serial slave that holds the configuration of a camera's analog front end. A host lowers the active-low select, clocks in one frame of address and data on the serial clock, and raises the select again. The block decodes the address and writes the data into one of five registers of unequal width. It drives these outputs:

- an auxiliary level code;
- two bandwidth codes;
- an amplifier gain code;
- a set of power-down and clock-edge flags;
- a clamp reference code.

The serial pins are asynchronous to the system clock. They pass through a synchronizer, and every decision is taken in the system clock domain. A frame is committed only when the select rises after exactly the expected number of bits. Any other frame is dropped without effect. A separate global standby input forces every power-down flag active. It does not disturb the stored settings, so the previous configuration returns as soon as standby is released.

Top module: `fe_ctrl_regs`

## Requirements
- R1: After reset every register output is 0: gain 0, both bandwidth codes 0, auxiliary and clamp codes 0, and all flags 0 (all blocks active).
- R2: A frame is 13 bits sent MSB first: address bits 2..0, then data bits 9..0. Each bit is sampled on a rising edge of `sclk_i` while `sen_ni` is 0. The frame is committed when `sen_ni` returns to 1.
- R3: If the number of bits clocked in while `sen_ni` was low is not exactly 13, the frame is discarded and no output changes.
- R4: Address 0 loads `aux_code_o` from data bits 7..0.
- R5: Address 1 loads `cds_bw_o` from data bits 3..0 and `agc_bw_o` from data bits 7..4. Data bits 9..8 are ignored.
- R6: Address 2 loads `gain_o` from data bits 8..0. A value above 319 is stored as 319.
- R7: Address 3 loads the flags from the data bits. Bit 0 drives `core_pd_o`, bit 1 drives `aux_pd_o`, bit 2 drives `amp_pd_o`, bit 3 drives `shp_fall_o`, bit 4 drives `clamp_hi_o` and bit 5 drives `adc_clk_rise_o`. Bits 9..6 are ignored.
- R8: Address 4 loads `clamp_ref_o` from data bits 9..0.
- R9: Addresses 5, 6 and 7 change no output.
- R10: While `stby_i` is 1, `core_pd_o`, `aux_pd_o` and `amp_pd_o` are 1 and all other outputs keep their stored values. When `stby_i` returns to 0, the stored power-down flags reappear.
- R11: Register outputs change only as the result of a committed frame. Once `sen_ni` has been steady for more than the synchronizer depth plus two clock cycles, every output except those forced by `stby_i` is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sen_ni | input | 1 | Serial select, active low |
| sdata_i | input | 1 | Serial data |
| stby_i | input | 1 | Global standby, active high |
| aux_code_o | output | 8 | Auxiliary level code |
| cds_bw_o | output | 4 | Sampler bandwidth code |
| agc_bw_o | output | 4 | Gain stage bandwidth code |
| gain_o | output | 9 | Gain code, 0..319 |
| core_pd_o | output | 1 | Sampler and gain stage power-down |
| aux_pd_o | output | 1 | Auxiliary converter power-down |
| amp_pd_o | output | 1 | Fixed-gain amplifier power-down |
| shp_fall_o | output | 1 | Sample pulses act on falling edge |
| clamp_hi_o | output | 1 | Clamp inputs active high |
| adc_clk_rise_o | output | 1 | Converter clock acts on rising edge |
| clamp_ref_o | output | 10 | Clamp reference code |

## Verification
The bench uses the default configuration: a two-stage synchronizer and a gain ceiling of 319. With these values a full serial frame takes under a hundred system cycles. That makes it affordable to sweep every gain code, including the whole saturated range above 319. The same budget covers all 64 flag patterns and a strided walk over the clamp and auxiliary codes. It also covers frames one bit short and one bit long, writes to all three unused addresses, and a standby pulse laid over stored flags.

// File: rtl/fe_ctrl_pkg.sv
package fe_ctrl_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 10;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int AUX_W   = 8;
  localparam int BW_W    = 4;
  localparam int GAIN_W  = 9;
  localparam int CLAMP_W = 10;

  typedef enum logic [ADDR_W-1:0] {
    ADR_AUX   = 3'd0,
    ADR_BW    = 3'd1,
    ADR_GAIN  = 3'd2,
    ADR_FLAG  = 3'd3,
    ADR_CLAMP = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic adc_clk_rise;
    logic clamp_hi;
    logic shp_fall;
    logic amp_pd;
    logic aux_pd;
    logic core_pd;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
endpackage

// File: rtl/fe_ctrl_sync.sv
module fe_ctrl_sync #(
  parameter int         STAGES  = 2,
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= RST_VAL;
      else         chain[s] <= (s == 0) ? d_i : chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/fe_ctrl_shift.sv
module fe_ctrl_shift
  import fe_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              sen_s_i,
  input  logic              sdata_s_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic               sclk_q, sen_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sclk_rise, sen_rise;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign sen_rise  = sen_s_i & ~sen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sen_q  <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      sen_q  <= sen_s_i;
      if (sen_s_i) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        sh_q <= {sh_q[FRAME_W-2:0], sdata_s_i};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Only a frame of exact length is accepted.
  assign commit_o = sen_rise && (cnt_q == CNT_W'(FRAME_W));
  assign addr_o   = sh_q[FRAME_W-1 -: ADDR_W];
  assign data_o   = sh_q[DATA_W-1:0];
endmodule

// File: rtl/fe_ctrl_bank.sv
module fe_ctrl_bank
  import fe_ctrl_pkg::*;
#(
  parameter int GAIN_MAX = 319
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [AUX_W-1:0]   aux_o,
  output logic [BW_W-1:0]    cds_bw_o,
  output logic [BW_W-1:0]    agc_bw_o,
  output logic [GAIN_W-1:0]  gain_o,
  output flags_t             flags_o,
  output logic [CLAMP_W-1:0] clamp_o
);
  localparam logic [GAIN_W-1:0] GAIN_CAP = GAIN_W'(GAIN_MAX);

  logic [GAIN_W-1:0] gain_raw, gain_sat;
  assign gain_raw = data_i[GAIN_W-1:0];
  assign gain_sat = (gain_raw > GAIN_CAP) ? GAIN_CAP : gain_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aux_o    <= '0;
      cds_bw_o <= '0;
      agc_bw_o <= '0;
      gain_o   <= '0;
      flags_o  <= '0;
      clamp_o  <= '0;
    end else if (commit_i) begin
      case (addr_i)
        ADR_AUX:   aux_o <= data_i[AUX_W-1:0];
        ADR_BW: begin
          cds_bw_o <= data_i[BW_W-1:0];
          agc_bw_o <= data_i[2*BW_W-1:BW_W];
        end
        ADR_GAIN:  gain_o  <= gain_sat;
        ADR_FLAG:  flags_o <= flags_t'(data_i[FLAG_W-1:0]);
        ADR_CLAMP: clamp_o <= data_i[CLAMP_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fe_ctrl_regs.sv
module fe_ctrl_regs
  import fe_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAIN_MAX    = 319
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sen_ni,
  input  logic               sdata_i,
  input  logic               stby_i,
  output logic [AUX_W-1:0]   aux_code_o,
  output logic [BW_W-1:0]    cds_bw_o,
  output logic [BW_W-1:0]    agc_bw_o,
  output logic [GAIN_W-1:0]  gain_o,
  output logic               core_pd_o,
  output logic               aux_pd_o,
  output logic               amp_pd_o,
  output logic               shp_fall_o,
  output logic               clamp_hi_o,
  output logic               adc_clk_rise_o,
  output logic [CLAMP_W-1:0] clamp_ref_o
);
  logic [2:0]        pins_s;
  logic              commit;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  flags_t            flags;

  // {sclk, sen, sdata}; select idles high
  fe_ctrl_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({sclk_i, sen_ni, sdata_i}),
    .q_o (pins_s)
  );

  fe_ctrl_shift u_shift (
    .clk_i, .rst_ni,
    .sclk_s_i  (pins_s[2]),
    .sen_s_i   (pins_s[1]),
    .sdata_s_i (pins_s[0]),
    .commit_o  (commit),
    .addr_o    (addr),
    .data_o    (data)
  );

  fe_ctrl_bank #(.GAIN_MAX(GAIN_MAX)) u_bank (
    .clk_i, .rst_ni,
    .commit_i (commit),
    .addr_i   (addr),
    .data_i   (data),
    .aux_o    (aux_code_o),
    .cds_bw_o (cds_bw_o),
    .agc_bw_o (agc_bw_o),
    .gain_o   (gain_o),
    .flags_o  (flags),
    .clamp_o  (clamp_ref_o)
  );

  // Standby overrides power-down flags only; stored bits untouched.
  assign core_pd_o      = flags.core_pd | stby_i;
  assign aux_pd_o       = flags.aux_pd  | stby_i;
  assign amp_pd_o       = flags.amp_pd  | stby_i;
  assign shp_fall_o     = flags.shp_fall;
  assign clamp_hi_o     = flags.clamp_hi;
  assign adc_clk_rise_o = flags.adc_clk_rise;
endmodule

// File: rtl/fe_ctrl_regs_chk.sv
module fe_ctrl_regs_chk
  import fe_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAIN_MAX    = 319
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sen_ni,
  input logic               stby_i,
  input logic [AUX_W-1:0]   aux_code_o,
  input logic [BW_W-1:0]    cds_bw_o,
  input logic [BW_W-1:0]    agc_bw_o,
  input logic [GAIN_W-1:0]  gain_o,
  input logic               core_pd_o,
  input logic               aux_pd_o,
  input logic               amp_pd_o,
  input logic               shp_fall_o,
  input logic               clamp_hi_o,
  input logic               adc_clk_rise_o,
  input logic [CLAMP_W-1:0] clamp_ref_o
);
  localparam int QUIET = SYNC_STAGES + 3;
  localparam int QW    = $clog2(QUIET + 1);

  logic          sen_q;
  logic [QW-1:0] quiet_q;
  logic          quiet;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sen_q   <= 1'b1;
      quiet_q <= '0;
    end else begin
      sen_q <= sen_ni;
      if (sen_ni != sen_q)               quiet_q <= '0;
      else if (quiet_q != QW'(QUIET))    quiet_q <= quiet_q + 1'b1;
    end
  end
  assign quiet = (quiet_q == QW'(QUIET));

  // R6
  gain_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_o <= GAIN_W'(GAIN_MAX));

  // R10
  stby_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |-> (core_pd_o && aux_pd_o && amp_pd_o));

  // R11
  codes_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |-> ($stable(aux_code_o) && $stable(cds_bw_o) && $stable(agc_bw_o)
               && $stable(gain_o) && $stable(clamp_ref_o)));

  // R11
  edge_flags_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |-> ($stable(shp_fall_o) && $stable(clamp_hi_o) && $stable(adc_clk_rise_o)));

  // R10
  pd_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !stby_i && !$past(stby_i)) |-> ($stable(core_pd_o) && $stable(aux_pd_o) && $stable(amp_pd_o)));
endmodule

bind fe_ctrl_regs fe_ctrl_regs_chk #(.SYNC_STAGES(SYNC_STAGES), .GAIN_MAX(GAIN_MAX)) u_chk (.*);

// File: tb/fe_ctrl_regs_test.sv
module fe_ctrl_regs_test;
  localparam int HP = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0, sen_ni = 1'b1, sdata_i = 1'b0, stby_i = 1'b0;
  logic [7:0] aux_code_o;
  logic [3:0] cds_bw_o, agc_bw_o;
  logic [8:0] gain_o;
  logic core_pd_o, aux_pd_o, amp_pd_o, shp_fall_o, clamp_hi_o, adc_clk_rise_o;
  logic [9:0] clamp_ref_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fe_ctrl_regs uut (
    .clk_i(clk), .rst_ni, .sclk_i, .sen_ni, .sdata_i, .stby_i,
    .aux_code_o, .cds_bw_o, .agc_bw_o, .gain_o,
    .core_pd_o, .aux_pd_o, .amp_pd_o, .shp_fall_o, .clamp_hi_o, .adc_clk_rise_o,
    .clamp_ref_o
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [13:0] bits, input int n);
    sen_ni = 1'b0;
    wait_clk(HP);
    for (int i = n - 1; i >= 0; i--) begin
      sdata_i = bits[i];
      sclk_i  = 1'b0;
      wait_clk(HP);
      sclk_i  = 1'b1;
      wait_clk(HP);
    end
    sclk_i = 1'b0;
    wait_clk(HP);
    sen_ni = 1'b1;
    wait_clk(8);
  endtask

  task automatic frame(input logic [2:0] a, input logic [9:0] d);
    send({1'b0, a, d}, 13);
  endtask

  function automatic int flags_now();
    return {adc_clk_rise_o, clamp_hi_o, shp_fall_o, amp_pd_o, aux_pd_o, core_pd_o};
  endfunction

  task automatic chk_all(input string req, input int aux, input int cds, input int agc,
                         input int gn, input int fl, input int cl);
    chk({req, " aux"}, aux_code_o, aux);
    chk({req, " cds_bw"}, cds_bw_o, cds);
    chk({req, " agc_bw"}, agc_bw_o, agc);
    chk({req, " gain"}, gain_o, gn);
    chk({req, " flags"}, flags_now(), fl);
    chk({req, " clamp"}, clamp_ref_o, cl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst_ni = 1'b1;
    wait_clk(4);
    // R1: reset state
    chk_all("R1", 0, 0, 0, 0, 0, 0);

    // R4 + R2: auxiliary code sweep
    for (int v = 0; v < 256; v += 5) begin
      frame(3'd0, 10'(v) | 10'h300);
      chk("R4 R2 aux", aux_code_o, v);
    end

    // R5: bandwidth codes, upper bits ignored
    for (int v = 0; v < 256; v += 17) begin
      frame(3'd1, 10'(v) | 10'h300);
      chk("R5 cds_bw", cds_bw_o, v % 16);
      chk("R5 agc_bw", agc_bw_o, v / 16);
    end

    // R6: full gain sweep including saturation
    for (int g = 0; g < 512; g++) begin
      frame(3'd2, 10'(g) | 10'h200);
      chk("R6 gain", gain_o, (g > 319) ? 319 : g);
    end

    // R7: all flag patterns with high bits set
    for (int f = 0; f < 64; f++) begin
      frame(3'd3, 10'(f) | 10'h3C0);
      chk("R7 flags", flags_now(), f);
    end

    // R8: clamp reference walk
    for (int c = 0; c < 1024; c += 7) begin
      frame(3'd4, 10'(c));
      chk("R8 clamp", clamp_ref_o, c);
    end
    frame(3'd4, 10'h3FF);
    chk("R8 clamp max", clamp_ref_o, 1023);

    // Known state
    frame(3'd0, 10'h0A5);
    frame(3'd1, 10'h03C);
    frame(3'd2, 10'd100);
    frame(3'd3, 10'h02A);
    frame(3'd4, 10'h155);
    chk_all("R2 setup", 8'hA5, 4'hC, 4'h3, 100, 6'h2A, 10'h155);

    // R9: unused addresses
    for (int a = 5; a < 8; a++) begin
      frame(3'(a), 10'h3FF);
      chk_all("R9", 8'hA5, 4'hC, 4'h3, 100, 6'h2A, 10'h155);
    end

    // R3: short frame (12 bits) and long frame (14 bits)
    send({1'b0, 3'd2, 10'd7}, 12);
    chk("R3 short", gain_o, 100);
    send({1'b0, 3'd2, 10'd7}, 14);
    chk("R3 long", gain_o, 100);
    send({1'b1, 3'd2, 10'd7}, 14);
    chk("R3 long2", gain_o, 100);
    send(14'd0, 0);
    chk_all("R3 empty", 8'hA5, 4'hC, 4'h3, 100, 6'h2A, 10'h155);
    frame(3'd2, 10'd7);
    chk("R3 recover", gain_o, 7);

    // R10: standby overlay
    frame(3'd3, 10'h000);
    stby_i = 1'b1;
    wait_clk(2);
    chk("R10 stby on", flags_now(), 6'h07);
    frame(3'd3, 10'h038);
    chk("R10 write under stby", flags_now(), 6'h3F);
    chk("R10 gain kept", gain_o, 7);
    stby_i = 1'b0;
    wait_clk(2);
    chk("R10 stby off", flags_now(), 6'h38);
    frame(3'd3, 10'h005);
    chk("R10 stored", flags_now(), 6'h05);

    // R11: idle cycles change nothing
    wait_clk(50);
    chk_all("R11", 8'hA5, 4'hC, 4'h3, 7, 6'h05, 10'h155);

    // R1: reset again
    rst_ni = 1'b0;
    wait_clk(2);
    rst_ni = 1'b1;
    wait_clk(2);
    chk_all("R1 rerun", 0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule